// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the maintenance traffic of an asynchronous DRAM that sits behind a separate access controller. After reset it keeps all strobes inactive for a programmable power-up delay. It then drives a fixed number of RAS-only dummy cycles and raises a ready flag. From then on, an interval timer adds one owed refresh per tick to a small debt counter. Each refresh is a CAS-before-RAS cycle, so the memory's own row counter selects the row and no address is driven.

While any refresh is owed, the block raises a request towards the access controller. It starts a refresh only while the grant input is high, and it issues owed refreshes back to back as long as the grant stays high. If the debt reaches its ceiling, an urgent flag tells the controller to close its open row and hand over the bus. Ordinary reads and writes also refresh rows, but the block does not count them. Its own pacing meets the retention window without them.

The interval parameter is meant to be set to the retention time divided by the row count (8 ms over 512 rows at the nominal figures), less the worst grant latency. The power-up delay is meant to be set to at least 200 µs of clock cycles.

Top module: `dram_maint_seq`

## Requirements
- R1: While reset is active, RAS and every CAS lane are high (inactive), and the request, urgent and ready outputs are low.
- R2: After reset is released, no RAS or CAS strobe goes low for at least PWRUP_CYC clock cycles.
- R3: After the power-up delay, exactly INIT_PULSES RAS pulses occur with every CAS lane held high. The ready output then rises and stays high until reset.
- R4: Every RAS low period lasts exactly RAS_LOW_CYC cycles, and RAS stays high for at least PRECHARGE_CYC cycles between two pulses.
- R5: Once ready, one refresh is owed every REF_INTERVAL_CYC cycles, counted from the cycle in which ready rose. Apart from debt lost to saturation (R8), the number of refreshes performed equals the number owed whenever the request is low.
- R6: A refresh starts only while the grant input is high. With the grant held high, consecutive refresh RAS falls are exactly REF_INTERVAL_CYC cycles apart.
- R7: In a refresh, all CAS lanes fall together and stay low for exactly CAS_SETUP_CYC cycles before RAS falls. They return high in the same cycle as RAS.
- R8: The urgent output is high exactly when MAX_DEFER refreshes are owed. The debt saturates at MAX_DEFER, and when the grant then arrives, exactly MAX_DEFER refreshes run back to back.
- R9: If an interval tick and the completion of a refresh fall in the same cycle, the debt is unchanged and no owed refresh is lost.
- R10: The request output is high while a refresh is owed or in progress. It falls once the last owed refresh has finished.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| grant_i | input | 1 | Access controller hands the DRAM bus to this block |
| req_o | output | 1 | Refresh owed or in progress |
| urgent_o | output | 1 | Debt at its ceiling; open row must be closed |
| init_done_o | output | 1 | Power-up and initialization finished |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | CAS_LANES | Column strobes, one per byte lane, active low |

## Verification
An interval tick can land in the same cycle in which a refresh completes. One change to the debt counter must then add one refresh and remove one. The bench withholds the grant until a refresh is owed, then raises it after a swept delay of a few cycles around interval minus sequence length. At one point in the sweep the completion edge coincides with the next tick. After each trial the bench waits for the request to drop. It then compares the number of refresh RAS falls it has seen with the number of ticks it computes from elapsed cycles, so a tick lost in the collision shows up as a shortfall.

// File: rtl/maint_pkg.sv
package maint_pkg;

  typedef enum logic [1:0] {
    STB_IDLE      = 2'd0,
    STB_CAS_SETUP = 2'd1,
    STB_RAS_LOW   = 2'd2,
    STB_PRECHARGE = 2'd3
  } stb_state_e;

  typedef enum logic [1:0] {
    PH_PWR_WAIT = 2'd0,
    PH_INIT     = 2'd1,
    PH_RUN      = 2'd2
  } phase_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/maint_strobe.sv
module maint_strobe
  import maint_pkg::*;
#(
  parameter int CAS_SETUP_CYC = 2,
  parameter int RAS_LOW_CYC   = 4,
  parameter int PRECHARGE_CYC = 3,
  parameter int CAS_LANES     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 cbr_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 ras_n_o,
  output logic [CAS_LANES-1:0] cas_n_o
);

  localparam int MAXC = max3(CAS_SETUP_CYC, RAS_LOW_CYC, PRECHARGE_CYC);
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LD_CS = CW'(CAS_SETUP_CYC - 1);
  localparam logic [CW-1:0] LD_RL = CW'(RAS_LOW_CYC - 1);
  localparam logic [CW-1:0] LD_PC = CW'(PRECHARGE_CYC - 1);

  stb_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cbr_q, cbr_d;
  logic          cnt_zero;
  logic          ras_n_d, cas_low_d;
  logic          ras_n_q;

  assign cnt_zero = (cnt_q == '0);

  // next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cbr_d   = cbr_q;
    done_o  = 1'b0;
    case (state_q)
      STB_IDLE: begin
        if (start_i) begin
          cbr_d = cbr_i;
          if (cbr_i) begin
            state_d = STB_CAS_SETUP;
            cnt_d   = LD_CS;
          end else begin
            state_d = STB_RAS_LOW;
            cnt_d   = LD_RL;
          end
        end
      end
      STB_CAS_SETUP: begin
        if (cnt_zero) begin
          state_d = STB_RAS_LOW;
          cnt_d   = LD_RL;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      STB_RAS_LOW: begin
        if (cnt_zero) begin
          state_d = STB_PRECHARGE;
          cnt_d   = LD_PC;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      STB_PRECHARGE: begin
        if (cnt_zero) begin
          state_d = STB_IDLE;
          done_o  = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = STB_IDLE;
    endcase
  end

  // strobe levels follow the next state so they leave a register directly
  always_comb begin
    ras_n_d   = (state_d != STB_RAS_LOW);
    cas_low_d = cbr_d && ((state_d == STB_CAS_SETUP) || (state_d == STB_RAS_LOW));
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= STB_IDLE;
      cnt_q   <= '0;
      cbr_q   <= 1'b0;
      ras_n_q <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cbr_q   <= cbr_d;
      ras_n_q <= ras_n_d;
    end
  end

  for (genvar g = 0; g < CAS_LANES; g++) begin : g_lane
    logic lane_n_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_n_q <= 1'b1;
      else        lane_n_q <= ~cas_low_d;
    end
    assign cas_n_o[g] = lane_n_q;
  end

  assign ras_n_o = ras_n_q;
  assign busy_o  = (state_q != STB_IDLE);

endmodule

// File: rtl/maint_powerup.sv
module maint_powerup
  import maint_pkg::*;
#(
  parameter int PWRUP_CYC   = 20000,
  parameter int INIT_PULSES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_busy_i,
  input  logic stb_done_i,
  output logic init_start_o,
  output logic init_done_o
);

  localparam int WW = $clog2(PWRUP_CYC + 1);
  localparam int PW = $clog2(INIT_PULSES + 1);
  localparam logic [WW-1:0] WAIT_LAST  = WW'(PWRUP_CYC - 1);
  localparam logic [PW-1:0] PULSE_LAST = PW'(INIT_PULSES - 1);

  phase_e        phase_q, phase_d;
  logic [WW-1:0] wait_q, wait_d;
  logic [PW-1:0] pulse_q, pulse_d;
  logic          wait_en, pulse_en;

  always_comb begin
    phase_d  = phase_q;
    wait_d   = wait_q;
    pulse_d  = pulse_q;
    wait_en  = 1'b0;
    pulse_en = 1'b0;
    case (phase_q)
      PH_PWR_WAIT: begin
        wait_en = 1'b1;
        if (wait_q == WAIT_LAST) begin
          phase_d = PH_INIT;
          wait_d  = '0;
        end else begin
          wait_d = wait_q + 1'b1;
        end
      end
      PH_INIT: begin
        if (stb_done_i) begin
          pulse_en = 1'b1;
          if (pulse_q == PULSE_LAST) begin
            phase_d = PH_RUN;
            pulse_d = '0;
          end else begin
            pulse_d = pulse_q + 1'b1;
          end
        end
      end
      default: phase_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_PWR_WAIT;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
    end else if (wait_en) begin
      wait_q <= wait_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= '0;
    end else if (pulse_en) begin
      pulse_q <= pulse_d;
    end
  end

  assign init_start_o = (phase_q == PH_INIT) && !stb_busy_i;
  assign init_done_o  = (phase_q == PH_RUN);

endmodule

// File: rtl/maint_pacer.sv
module maint_pacer #(
  parameter int REF_INTERVAL_CYC = 1500,
  parameter int MAX_DEFER        = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic done_i,
  output logic owed_o,
  output logic urgent_o
);

  localparam int TW = $clog2(REF_INTERVAL_CYC);
  localparam int DW = $clog2(MAX_DEFER + 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(REF_INTERVAL_CYC - 1);
  localparam logic [DW-1:0] DEBT_MAX  = DW'(MAX_DEFER);

  logic [TW-1:0] tmr_q, tmr_d;
  logic [DW-1:0] debt_q, debt_d;
  logic          tick;
  logic          debt_en;

  always_comb begin
    tick = run_i && (tmr_q == TICK_LAST);
    if (!run_i || tick) tmr_d = '0;
    else                tmr_d = tmr_q + 1'b1;
  end

  // a tick and a completion in the same cycle cancel out
  always_comb begin
    debt_d  = debt_q;
    debt_en = 1'b0;
    if (tick && !done_i) begin
      if (debt_q != DEBT_MAX) begin
        debt_d  = debt_q + 1'b1;
        debt_en = 1'b1;
      end
    end else if (!tick && done_i) begin
      if (debt_q != '0) begin
        debt_d  = debt_q - 1'b1;
        debt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else begin
      tmr_q <= tmr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      debt_q <= '0;
    end else if (debt_en) begin
      debt_q <= debt_d;
    end
  end

  assign owed_o   = (debt_q != '0);
  assign urgent_o = (debt_q == DEBT_MAX);

endmodule

// File: rtl/dram_maint_seq.sv
module dram_maint_seq #(
  parameter int PWRUP_CYC        = 20000,
  parameter int INIT_PULSES      = 8,
  parameter int REF_INTERVAL_CYC = 1500,
  parameter int MAX_DEFER        = 4,
  parameter int CAS_SETUP_CYC    = 2,
  parameter int RAS_LOW_CYC      = 4,
  parameter int PRECHARGE_CYC    = 3,
  parameter int CAS_LANES        = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 grant_i,
  output logic                 req_o,
  output logic                 urgent_o,
  output logic                 init_done_o,
  output logic                 ras_n_o,
  output logic [CAS_LANES-1:0] cas_n_o
);

  logic rst_meta_q, rst_sync_q;
  logic stb_busy, stb_done, stb_start;
  logic init_start, run;
  logic owed, ref_done;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  maint_powerup #(
    .PWRUP_CYC  (PWRUP_CYC),
    .INIT_PULSES(INIT_PULSES)
  ) u_pwr (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .stb_busy_i  (stb_busy),
    .stb_done_i  (stb_done),
    .init_start_o(init_start),
    .init_done_o (run)
  );

  maint_pacer #(
    .REF_INTERVAL_CYC(REF_INTERVAL_CYC),
    .MAX_DEFER       (MAX_DEFER)
  ) u_pace (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .run_i   (run),
    .done_i  (ref_done),
    .owed_o  (owed),
    .urgent_o(urgent_o)
  );

  assign ref_done  = run && stb_done;
  assign stb_start = init_start || (run && owed && grant_i && !stb_busy);

  maint_strobe #(
    .CAS_SETUP_CYC(CAS_SETUP_CYC),
    .RAS_LOW_CYC  (RAS_LOW_CYC),
    .PRECHARGE_CYC(PRECHARGE_CYC),
    .CAS_LANES    (CAS_LANES)
  ) u_stb (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .start_i(stb_start),
    .cbr_i  (run),
    .busy_o (stb_busy),
    .done_o (stb_done),
    .ras_n_o(ras_n_o),
    .cas_n_o(cas_n_o)
  );

  assign req_o       = run && (owed || stb_busy);
  assign init_done_o = run;

endmodule

// File: rtl/dram_maint_seq_chk.sv
module dram_maint_seq_chk #(
  parameter int PWRUP_CYC = 20000,
  parameter int CAS_LANES = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 grant_i,
  input logic                 req_o,
  input logic                 urgent_o,
  input logic                 init_done_o,
  input logic                 ras_n_o,
  input logic [CAS_LANES-1:0] cas_n_o
);

  logic [31:0] up_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= '0;
    else if (up_q != 32'hFFFF_FFFF) up_q <= up_q + 32'd1;
  end

  AST_PWRUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n_o || (cas_n_o != '1)) |-> (up_q >= 32'(PWRUP_CYC))); // R2

  AST_INIT_NO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done_o |-> (cas_n_o == '1)); // R3

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_o |=> init_done_o); // R3

  AST_CAS_BEFORE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done_o && $fell(ras_n_o)) |-> ((cas_n_o == '0) && $past(cas_n_o == '0))); // R7

  AST_CAS_UP_WITH_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done_o && $rose(cas_n_o[0])) |-> ras_n_o); // R7

  AST_START_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done_o && $fell(cas_n_o[0])) |-> $past(grant_i)); // R6

  AST_URGENT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    urgent_o |-> req_o); // R8

endmodule

bind dram_maint_seq dram_maint_seq_chk #(
  .PWRUP_CYC(PWRUP_CYC),
  .CAS_LANES(CAS_LANES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .grant_i    (grant_i),
  .req_o      (req_o),
  .urgent_o   (urgent_o),
  .init_done_o(init_done_o),
  .ras_n_o    (ras_n_o),
  .cas_n_o    (cas_n_o)
);

// File: tb/dram_maint_seq_test.sv
module dram_maint_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int P_PWR   = 200;
  localparam int P_INIT  = 8;
  localparam int P_IVL   = 60;
  localparam int P_DEF   = 4;
  localparam int P_CS    = 2;
  localparam int P_RL    = 4;
  localparam int P_PC    = 3;
  localparam int P_LANES = 2;
  localparam int SEQ_LEN = P_CS + P_RL + P_PC;

  logic               clk;
  logic               rst_n;
  logic               grant;
  logic               req, urgent, init_done, ras_n;
  logic [P_LANES-1:0] cas_n;

  int  errors = 0;
  int  checks = 0;
  int  n_run = 0;
  bit  seen_ready = 0;
  int  cbr_falls = 0;
  int  init_falls = 0;
  int  lost = 0;
  bit  cas_in_init = 0;
  int  ras_low_len = 0;
  int  ras_high_len = 0;
  int  cas_len = 0;
  bit  prev_ras = 1;
  bit  had_pulse = 0;
  int  last_fall_n = 0;

  dram_maint_seq #(
    .PWRUP_CYC       (P_PWR),
    .INIT_PULSES     (P_INIT),
    .REF_INTERVAL_CYC(P_IVL),
    .MAX_DEFER       (P_DEF),
    .CAS_SETUP_CYC   (P_CS),
    .RAS_LOW_CYC     (P_RL),
    .PRECHARGE_CYC   (P_PC),
    .CAS_LANES       (P_LANES)
  ) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant_i    (grant),
    .req_o      (req),
    .urgent_o   (urgent),
    .init_done_o(init_done),
    .ras_n_o    (ras_n),
    .cas_n_o    (cas_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // strobe monitor, sampled on the falling clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (init_done && !seen_ready) begin
        seen_ready = 1;
        n_run = 0;
      end else if (seen_ready) begin
        n_run++;
      end
      if (!init_done && (cas_n != '1)) cas_in_init = 1;
      if (prev_ras && !ras_n) begin
        if (had_pulse) chk(ras_high_len >= P_PC, "R4 precharge", ras_high_len, P_PC);
        had_pulse = 1;
        if (!init_done) begin
          init_falls++;
        end else begin
          cbr_falls++;
          last_fall_n = n_run;
          chk(cas_len == P_CS, "R7 cas setup", cas_len, P_CS);
          chk(cas_n == '0, "R7 all lanes low", int'(cas_n), 0);
        end
      end
      if (!prev_ras && ras_n) begin
        chk(ras_low_len == P_RL, "R4 ras width", ras_low_len, P_RL);
        if (init_done) chk(cas_n == '1, "R7 cas rises with ras", int'(cas_n), 3);
      end
      if (!ras_n) begin
        ras_low_len++;
        ras_high_len = 0;
      end else begin
        ras_low_len = 0;
        ras_high_len++;
      end
      if (ras_n) begin
        if (cas_n == '0) cas_len++;
        else cas_len = 0;
      end
      prev_ras = ras_n;
    end
  end

  task automatic quiet_count(input string tag);
    int owed;
    owed = n_run / P_IVL - lost;
    chk(cbr_falls == owed, tag, cbr_falls, owed);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    grant = 1'b0;
    repeat (5) @(negedge clk);
    chk(ras_n == 1'b1, "R1 ras", int'(ras_n), 1);
    chk(cas_n == '1, "R1 cas", int'(cas_n), 3);
    chk({req, urgent, init_done} == 3'b000, "R1 flags", int'({req, urgent, init_done}), 0);
  endtask

  task automatic t_powerup;
    int cyc;
    cyc = 0;
    rst_n = 1'b1;
    while (ras_n && (cas_n == '1) && cyc < P_PWR + 50) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc >= P_PWR, "R2 quiet wait", cyc, P_PWR);
    chk(cyc <= P_PWR + 6, "R2 wait bound", cyc, P_PWR + 6);
  endtask

  task automatic t_init;
    while (!init_done) @(negedge clk);
    chk(init_falls == P_INIT, "R3 init pulses", init_falls, P_INIT);
    chk(cas_in_init == 0, "R3 cas idle in init", int'(cas_in_init), 0);
    chk(req == 1'b0, "R10 no request at ready", int'(req), 0);
    repeat (3) @(negedge clk);
    chk(init_done == 1'b1, "R3 ready holds", int'(init_done), 1);
  endtask

  task automatic t_gap;
    int f0, n0, gap;
    grant = 1'b1;
    f0 = cbr_falls;
    while (cbr_falls == f0) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      n0 = last_fall_n;
      f0 = cbr_falls;
      while (cbr_falls == f0) @(negedge clk);
      gap = last_fall_n - n0;
      chk(gap == P_IVL, "R6 refresh gap", gap, P_IVL);
    end
    repeat (SEQ_LEN + 2) @(negedge clk);
    chk(req == 1'b0, "R10 request drops", int'(req), 0);
    quiet_count("R5 owed vs done");
  endtask

  task automatic t_coincide;
    for (int off = 0; off < 7; off++) begin
      grant = 1'b0;
      while (!req) @(negedge clk);
      repeat (P_IVL - SEQ_LEN - 3 + off) @(negedge clk);
      grant = 1'b1;
      while (req) @(negedge clk);
      quiet_count("R9 tick meets completion");
    end
  endtask

  task automatic t_defer;
    int f0;
    grant = 1'b0;
    while (!req) @(negedge clk);
    repeat ((P_DEF - 1) * P_IVL - 1) @(negedge clk);
    chk(urgent == 1'b0, "R8 urgent below ceiling", int'(urgent), 0);
    @(negedge clk);
    chk(urgent == 1'b1, "R8 urgent at ceiling", int'(urgent), 1);
    chk(req == 1'b1, "R10 request while owed", int'(req), 1);
    repeat (2 * P_IVL + 5) @(negedge clk);
    chk(urgent == 1'b1, "R8 urgent saturated", int'(urgent), 1);
    chk(cas_n == '1, "R6 no refresh without grant", int'(cas_n), 3);
    f0 = cbr_falls;
    grant = 1'b1;
    while (req) @(negedge clk);
    chk(cbr_falls - f0 == P_DEF, "R8 drained refreshes", cbr_falls - f0, P_DEF);
    chk(urgent == 1'b0, "R8 urgent clears", int'(urgent), 0);
    lost += 2;
    quiet_count("R5 owed after saturation");
  endtask

  initial begin
    t_reset();
    @(negedge clk);
    t_powerup();
    t_init();
    t_gap();
    t_coincide();
    t_defer();
    t_gap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R10 actual=%0d expected=%0d", 20000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule